// File: doc/BRIEF.md
# Edge/Level Interrupt Request Latch

This block turns eight raw interrupt request lines into a register of pending requests. Each line has its own sensing mode, kept in a trigger-mode register. In level mode a pending bit simply follows the line. In edge mode a pending bit is captured on a low-to-high change and then held until the interrupt is acknowledged. The block keeps the level each line had at the previous sample so that it can see edges.

A downstream priority resolver reads the pending vector. It sends back an acknowledge strobe with the index of the input it serviced. An initialization pulse restarts edge sensing, so an edge-mode line that is already high has to fall and rise again before it counts as a request. Masking, arbitration and vector generation are done elsewhere. The trigger-mode register is written through an AND with a fixed per-instance mask, so that inputs with no level capability always stay in edge mode.

Top module: `irq_req_latch`

## Requirements
- R1: While synchronous reset is high, and in the first cycle after it, `pending` and `trig_mode` are all zero.
- R2: A write with `trig_wr_en` high stores `trig_wr_data & TRIG_MASK`, which is readable on `trig_mode` one cycle later. A bit value of 1 selects level mode and 0 selects edge mode. With the default mask 0xF8, inputs 0 to 2 can never leave edge mode.
- R3: For a level-mode input, `pending[i]` equals the value `req_in[i]` had at the previous clock edge.
- R4: For an edge-mode input, `pending[i]` is set when the input is sampled high and its previous sample was low. A line that is held high does not produce a second request.
- R5: An edge-mode pending bit stays set while its input is low, until it is acknowledged or initialization occurs.
- R6: An acknowledge with `ack_idx` naming an edge-mode input clears that pending bit in the next cycle.
- R7: An acknowledge naming a level-mode input has no effect on its pending bit.
- R8: If a new rising edge arrives on an edge-mode input in the same cycle as an acknowledge of that input, the pending bit stays set.
- R9: `init_pulse` clears every edge-mode pending bit in the next cycle. Level-mode pending bits keep following their inputs.
- R10: After initialization, an edge-mode input that stayed high through the pulse raises no request until it has been sampled low and then high.
- R11: The previous-level record is updated every cycle in both modes. An input that is already high when it is switched from level mode to edge mode does not count as a new edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_in | input | N_IN | Raw request levels, sampled each cycle |
| trig_wr_en | input | 1 | Write strobe for the trigger-mode register |
| trig_wr_data | input | N_IN | Trigger-mode write value (1 = level, 0 = edge) |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_idx | input | $clog2(N_IN) | Index of the acknowledged input |
| init_pulse | input | 1 | Initialization pulse |
| pending | output | N_IN | Pending-request vector |
| trig_mode | output | N_IN | Stored, masked trigger-mode register |

## Verification
Each result of this block appears exactly one clock edge after its stimulus. Pending bits react to the inputs, the acknowledge and the init pulse sampled at that edge. A trigger-mode write becomes visible on `trig_mode` and starts governing sensing only from the next edge. The driver applies one stimulus per cycle at the falling edge and queues the expected vectors for that stimulus. The monitor checks them shortly after the following rising edge, so every comparison is aligned to that single register stage. The corner cases covered are ack and edge in the same cycle, a line held high across init, and a mode switch on a high line.

// File: rtl/irq_latch_pkg.sv
package irq_latch_pkg;

    typedef enum logic {
        TRIG_EDGE  = 1'b0,
        TRIG_LEVEL = 1'b1
    } trig_e;

    typedef struct packed {
        logic pend;
        logic hist;
    } cell_state_t;

endpackage

// File: rtl/irq_trig_reg.sv
module irq_trig_reg #(
    parameter int          N_IN      = 8,
    parameter logic [N_IN-1:0] TRIG_MASK = 8'hF8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [N_IN-1:0] wr_data,
    output logic [N_IN-1:0] mode
);

    logic [N_IN-1:0] mode_d, mode_q;

    always_comb begin
        mode_d = mode_q;
        if (wr_en) begin
            mode_d = wr_data & TRIG_MASK;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
        end else begin
            mode_q <= mode_d;
        end
    end

    assign mode = mode_q;

endmodule

// File: rtl/irq_req_cell.sv
module irq_req_cell
    import irq_latch_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic req,
    input  logic level_mode,
    input  logic ack_hit,
    input  logic init,
    output logic pending
);

    cell_state_t st_d, st_q;
    logic        rise;

    always_comb begin
        rise = req & ~st_q.hist;
        st_d = st_q;
        // the live level always becomes the new history sample
        st_d.hist = req;
        if (trig_e'(level_mode) == TRIG_LEVEL) begin
            st_d.pend = req;
        end else if (init) begin
            st_d.pend = 1'b0;
        end else begin
            if (ack_hit) begin
                st_d.pend = 1'b0;
            end
            if (rise) begin
                st_d.pend = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pending = st_q.pend;

endmodule

// File: rtl/irq_req_latch.sv
module irq_req_latch #(
    parameter int              N_IN      = 8,
    parameter logic [N_IN-1:0] TRIG_MASK = 8'hF8,
    localparam int             IDXW      = (N_IN > 1) ? $clog2(N_IN) : 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [N_IN-1:0] req_in,
    input  logic            trig_wr_en,
    input  logic [N_IN-1:0] trig_wr_data,
    input  logic            ack_valid,
    input  logic [IDXW-1:0] ack_idx,
    input  logic            init_pulse,
    output logic [N_IN-1:0] pending,
    output logic [N_IN-1:0] trig_mode
);

    logic [N_IN-1:0] ack_hit;

    irq_trig_reg #(
        .N_IN      (N_IN),
        .TRIG_MASK (TRIG_MASK)
    ) u_trig (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (trig_wr_en),
        .wr_data (trig_wr_data),
        .mode    (trig_mode)
    );

    for (genvar g = 0; g < N_IN; g++) begin : g_cell
        assign ack_hit[g] = ack_valid && (ack_idx == IDXW'(g));

        irq_req_cell u_cell (
            .clk        (clk),
            .rst        (rst),
            .req        (req_in[g]),
            .level_mode (trig_mode[g]),
            .ack_hit    (ack_hit[g]),
            .init       (init_pulse),
            .pending    (pending[g])
        );
    end

endmodule

// File: rtl/irq_req_latch_chk.sv
module irq_req_latch_chk #(
    parameter int              N_IN      = 8,
    parameter logic [N_IN-1:0] TRIG_MASK = 8'hF8,
    localparam int             IDXW      = (N_IN > 1) ? $clog2(N_IN) : 1
) (
    input logic            clk,
    input logic            rst,
    input logic [N_IN-1:0] req_in,
    input logic            ack_valid,
    input logic [IDXW-1:0] ack_idx,
    input logic            init_pulse,
    input logic [N_IN-1:0] pending,
    input logic [N_IN-1:0] trig_mode
);

    // R2
    trig_masked_chk: assert property (@(posedge clk) disable iff (rst)
        (trig_mode & ~TRIG_MASK) == '0);

    for (genvar g = 0; g < N_IN; g++) begin : g_bit
        // R3
        level_follow_chk: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && $past(trig_mode[g])) |-> (pending[g] == $past(req_in[g])));

        // R4
        edge_set_chk: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && !$past(trig_mode[g]) && !$past(pending[g]) && pending[g])
            |-> $past(req_in[g]));

        // R5
        edge_hold_chk: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && !$past(trig_mode[g]) && $past(pending[g]) && !$past(init_pulse)
             && !($past(ack_valid) && $past(ack_idx) == IDXW'(g))) |-> pending[g]);

        // R6
        ack_clear_chk: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && !$past(trig_mode[g]) && $past(ack_valid)
             && $past(ack_idx) == IDXW'(g) && !$past(req_in[g])) |-> !pending[g]);

        // R9
        init_clear_chk: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && $past(init_pulse) && !$past(trig_mode[g])) |-> !pending[g]);
    end

endmodule

bind irq_req_latch irq_req_latch_chk #(
    .N_IN      (N_IN),
    .TRIG_MASK (TRIG_MASK)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_in     (req_in),
    .ack_valid  (ack_valid),
    .ack_idx    (ack_idx),
    .init_pulse (init_pulse),
    .pending    (pending),
    .trig_mode  (trig_mode)
);

// File: tb/irq_req_latch_test.sv
`timescale 1ns/1ps
module irq_req_latch_test;

    localparam logic [7:0] MASK = 8'hF8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] req_in = '0;
    logic       trig_wr_en = 1'b0;
    logic [7:0] trig_wr_data = '0;
    logic       ack_valid = 1'b0;
    logic [2:0] ack_idx = '0;
    logic       init_pulse = 1'b0;
    logic [7:0] pending;
    logic [7:0] trig_mode;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [7:0] pend;
        logic [7:0] trig;
        string      tag;
    } exp_t;

    exp_t sb_q[$];

    // bench-side model state
    logic [7:0] m_pend = '0;
    logic [7:0] m_hist = '0;
    logic [7:0] m_trig = '0;

    always #2 clk = ~clk;

    irq_req_latch #(.N_IN(8), .TRIG_MASK(MASK)) uut (
        .clk          (clk),
        .rst          (rst),
        .req_in       (req_in),
        .trig_wr_en   (trig_wr_en),
        .trig_wr_data (trig_wr_data),
        .ack_valid    (ack_valid),
        .ack_idx      (ack_idx),
        .init_pulse   (init_pulse),
        .pending      (pending),
        .trig_mode    (trig_mode)
    );

    task automatic compare(input logic [7:0] act_p, input logic [7:0] exp_p,
                           input logic [7:0] act_t, input logic [7:0] exp_t_v,
                           input string tag);
        checks++;
        if (act_p !== exp_p) begin
            errors++;
            $display("FAIL %s pending actual=%02h expected=%02h", tag, act_p, exp_p);
        end
        checks++;
        if (act_t !== exp_t_v) begin
            errors++;
            $display("FAIL %s trig_mode actual=%02h expected=%02h", tag, act_t, exp_t_v);
        end
    endtask

    // driver: one stimulus per cycle, expected result queued for the next edge
    task automatic step(input logic [7:0] r, input logic wr, input logic [7:0] wd,
                        input logic av, input logic [2:0] ai, input logic ini,
                        input string tag);
        exp_t e;
        @(negedge clk);
        req_in = r; trig_wr_en = wr; trig_wr_data = wd;
        ack_valid = av; ack_idx = ai; init_pulse = ini;
        for (int i = 0; i < 8; i++) begin
            if (m_trig[i]) begin
                m_pend[i] = r[i];
            end else if (ini) begin
                m_pend[i] = 1'b0;
            end else begin
                if (av && ai == 3'(i)) m_pend[i] = 1'b0;
                if (r[i] && !m_hist[i]) m_pend[i] = 1'b1;
            end
        end
        m_hist = r;
        if (wr) m_trig = wd & MASK;
        e.pend = m_pend; e.trig = m_trig; e.tag = tag;
        sb_q.push_back(e);
    endtask

    // monitor: pop and compare just after each rising edge
    initial begin
        exp_t e;
        forever begin
            @(posedge clk);
            #1;
            if (sb_q.size() > 0) begin
                e = sb_q.pop_front();
                compare(pending, e.pend, trig_mode, e.trig, e.tag);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        compare(pending, 8'h00, trig_mode, 8'h00, "R1 in reset");
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #1;
        compare(pending, 8'h00, trig_mode, 8'h00, "R1 after reset");

        step(8'h00, 1, 8'hFF, 0, 0, 0, "R2 masked write");
        step(8'h10, 0, 8'h00, 0, 0, 0, "R3 level high");
        step(8'h00, 0, 8'h00, 0, 0, 0, "R3 level low");
        step(8'h01, 0, 8'h00, 0, 0, 0, "R4 edge rise");
        step(8'h01, 0, 8'h00, 0, 0, 0, "R4 held high");
        step(8'h00, 0, 8'h00, 0, 0, 0, "R5 hold while low");
        step(8'h00, 0, 8'h00, 1, 3'd0, 0, "R6 ack edge");
        step(8'h10, 0, 8'h00, 0, 0, 0, "R7 level set");
        step(8'h10, 0, 8'h00, 1, 3'd4, 0, "R7 ack level");
        step(8'h02, 0, 8'h00, 0, 0, 0, "R8 first edge");
        step(8'h00, 0, 8'h00, 0, 0, 0, "R8 low");
        step(8'h02, 0, 8'h00, 1, 3'd1, 0, "R8 edge with ack");
        step(8'h15, 0, 8'h00, 0, 0, 0, "R9 set up");
        step(8'h15, 0, 8'h00, 0, 0, 1, "R9 init");
        step(8'h15, 0, 8'h00, 0, 0, 0, "R10 held after init");
        step(8'h11, 0, 8'h00, 0, 0, 0, "R10 drop");
        step(8'h15, 0, 8'h00, 0, 0, 0, "R10 fresh rise");
        step(8'h08, 0, 8'h00, 0, 0, 0, "R11 level high");
        step(8'h08, 1, 8'hF0, 0, 0, 0, "R11 switch to edge");
        step(8'h08, 0, 8'h00, 1, 3'd3, 0, "R11 ack after switch");
        step(8'h08, 0, 8'h00, 0, 0, 0, "R11 held no edge");

        for (int k = 0; k < 300; k++) begin
            logic [31:0] rv;
            rv = $urandom;
            step(8'($urandom), (rv[3:0] == 4'd0), 8'($urandom),
                 rv[4], rv[7:5], (rv[12:8] == 5'd0), "R4 mixed traffic");
        end

        while (sb_q.size() > 0) @(posedge clk);
        repeat (2) @(posedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule